// File: doc/BRIEF.md
# Readout Control Command Decoder

This block sits between a slow-control host and the acquisition and configuration agents of one readout chain. The host writes command bytes over an 8-bit parallel port, marking each byte with a rising edge on a strobe-in line. The decoder synchronises that strobe into the core clock domain, frames the bytes into commands and dispatches each command to one of four agents. These are the readout controller (send a data block), a DAC threshold writer that takes a channel and a 16-bit word, a TDC configuration engine and a TDC configuration verifier. Each dispatch is a request that stays up until the agent acknowledges it.

Replies travel back on an 8-bit output bus. Each reply byte is marked by a pulse on a strobe-out line, with the data steady for the whole pulse. Two queries exist. A status query returns the busy state of every agent, a sticky error flag and the result of the last verify. A settings query returns the current run number. The decoder also holds the run number register that the data formatter reads, and the host writes it with its own command.

Top module: `cmd_decoder`

## Requirements
- R1: After reset no request is raised, host_stb_out is low, run_num is zero, and a status query returns 0x00 then 0x00.
- R2: Each rising edge of host_stb_in delivers exactly one byte, however long the strobe stays high.
- R3: Opcode 0x01 raises rd_req, 0x03 raises cfg_req and 0x04 raises vfy_req. Each request stays high until its own ack is seen, then falls in the next cycle.
- R4: Opcode 0x02 is followed by a channel byte, a high data byte and a low data byte. It raises dac_req with dac_chan taken from the channel byte and dac_word = {high, low}. The request stays high until dac_ack, and dac_chan and dac_word stay steady while it is high.
- R5: A threshold command whose channel byte is 4 or more raises no request and sets the error flag.
- R6: Opcode 0x06 followed by four bytes loads run_num with those bytes, most significant byte first.
- R7: Opcode 0x07 returns the four run_num bytes, most significant first. Each byte is presented on host_dout with one host_stb_out pulse, and the data is steady while the pulse is high.
- R8: Opcode 0x05 returns two bytes. The first is {4'b0, verify, configure, threshold, data}, with data busy in bit 0. The second is {6'b0, last verify pass, error}, with error in bit 0.
- R9: Any opcode outside 0x01..0x07 raises no request and sets the error flag, which then stays set until reset.
- R10: While a dispatched request awaits its ack, opcodes 0x01, 0x02, 0x03, 0x04 and 0x06 are dropped and set the error flag, while 0x05 and 0x07 are still answered. At most one request is high at any time.
- R11: An ack that arrives in the same cycle as a decoded opcode counts as done for that opcode. A dispatch is accepted without error, and a status query reports that agent as idle.
- R12: The level of vfy_pass in the cycle of a vfy_ack that completes a verify request becomes the last verify pass bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_din | input | 8 | Command byte from host, steady around its strobe |
| host_stb_in | input | 1 | Host byte strobe, one byte per rising edge |
| host_dout | output | 8 | Reply byte to host |
| host_stb_out | output | 1 | Reply byte strobe, one pulse per byte |
| rd_req | output | 1 | Data transmission request to readout controller |
| rd_ack | input | 1 | Readout controller acknowledge |
| dac_req | output | 1 | Threshold write request |
| dac_chan | output | 2 | Threshold channel index |
| dac_word | output | 16 | Threshold DAC word |
| dac_ack | input | 1 | Threshold writer acknowledge |
| cfg_req | output | 1 | TDC configure request |
| cfg_ack | input | 1 | TDC configure acknowledge |
| vfy_req | output | 1 | TDC verify request |
| vfy_ack | input | 1 | TDC verify acknowledge |
| vfy_pass | input | 1 | Verify result, valid with vfy_ack |
| run_num | output | 32 | Current run number |

## Verification
An agent's acknowledge can land in the same cycle as the decoder evaluates a new opcode. The bench provokes this by timing the ack to the known synchroniser latency of the strobe: a status query is sent while the configure agent is busy, and separately a data request is sent behind an outstanding configure. The outcome is judged at the ports. The status byte must show the configure agent idle, and the data request must be raised with the error flag still clear.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

    typedef enum logic [7:0] {
        OP_DATA = 8'h01,
        OP_THR  = 8'h02,
        OP_CFG  = 8'h03,
        OP_VFY  = 8'h04,
        OP_STAT = 8'h05,
        OP_RUN  = 8'h06,
        OP_SETT = 8'h07
    } opcode_e;

    // index of each agent inside the pending vector
    localparam int AG_RD  = 0;
    localparam int AG_DAC = 1;
    localparam int AG_CFG = 2;
    localparam int AG_VFY = 3;
    localparam int NUM_AGENTS = 4;

    typedef enum logic {
        PS_OPCODE,
        PS_ARGS
    } pstate_e;

    function automatic logic [NUM_AGENTS-1:0] agent_bit(input int idx);
        return NUM_AGENTS'(1) << idx;
    endfunction

endpackage

// File: rtl/cmdec_strobe_rx.sv
module cmdec_strobe_rx #(
    parameter int SYNC = 2,
    parameter int BW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] din,
    input  logic          stb,
    output logic          byte_valid,
    output logic [BW-1:0] byte_data
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic [BW-1:0]   din_q;

    genvar g;
    generate
        for (g = 0; g < SYNC; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= stb;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            din_q  <= '0;
        end else begin
            prev_q <= sync_q[SYNC-1];
            din_q  <= din;
        end
    end

    assign byte_valid = sync_q[SYNC-1] & ~prev_q;
    assign byte_data  = din_q;
endmodule

// File: rtl/cmdec_parser.sv
module cmdec_parser
    import cmdec_pkg::*;
#(
    parameter int RUN_W    = 32,
    parameter int DAC_W    = 16,
    parameter int NCH_USED = 4,
    parameter int CH_W     = 2,
    parameter int MAXB     = 4,
    parameter int LEN_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bv,
    input  logic [7:0]            bdat,
    input  logic [NUM_AGENTS-1:0] ack,
    input  logic                  vfy_pass,
    input  logic                  tx_busy,
    output logic [NUM_AGENTS-1:0] pend,
    output logic [CH_W-1:0]       dac_chan,
    output logic [DAC_W-1:0]      dac_word,
    output logic [RUN_W-1:0]      run_num,
    output logic                  tx_load,
    output logic [MAXB*8-1:0]     tx_data,
    output logic [LEN_W-1:0]      tx_len
);
    localparam int RUN_ARGS = RUN_W / 8;
    localparam int THR_ARGS = 1 + DAC_W / 8;
    localparam int ARG_MAX  = (RUN_ARGS > THR_ARGS) ? RUN_ARGS : THR_ARGS;
    localparam int CNT_W    = $clog2(ARG_MAX + 1);
    localparam int SR_W     = (RUN_W > DAC_W) ? RUN_W : DAC_W;

    pstate_e              st, nx_st;
    logic [CNT_W-1:0]     cnt, nx_cnt;
    logic                 is_thr, nx_thr;
    logic [SR_W-1:0]      sr;
    logic                 err, last_pass;

    logic [NUM_AGENTS-1:0] ack_eff, pend_left, set_bits;
    logic                  busy_now, pass_now, err_set, ld_dac, ld_run;
    logic [7:0]            chan_byte;

    always_comb begin
        ack_eff   = ack & pend;
        pend_left = pend & ~ack;
        busy_now  = |pend_left;
        pass_now  = ack_eff[AG_VFY] ? vfy_pass : last_pass;
        chan_byte = sr[DAC_W-8 +: 8];

        nx_st    = st;
        nx_cnt   = cnt;
        nx_thr   = is_thr;
        set_bits = '0;
        err_set  = 1'b0;
        ld_dac   = 1'b0;
        ld_run   = 1'b0;
        tx_load  = 1'b0;
        tx_data  = '0;
        tx_len   = '0;

        if (bv) begin
            if (st == PS_OPCODE) begin
                case (bdat)
                    OP_DATA: if (busy_now) err_set = 1'b1; else set_bits = agent_bit(AG_RD);
                    OP_CFG:  if (busy_now) err_set = 1'b1; else set_bits = agent_bit(AG_CFG);
                    OP_VFY:  if (busy_now) err_set = 1'b1; else set_bits = agent_bit(AG_VFY);
                    OP_THR, OP_RUN: begin
                        if (busy_now) err_set = 1'b1;
                        else begin
                            nx_st  = PS_ARGS;
                            nx_thr = (bdat == OP_THR);
                            nx_cnt = (bdat == OP_THR) ? CNT_W'(THR_ARGS - 1) : CNT_W'(RUN_ARGS - 1);
                        end
                    end
                    OP_STAT: begin
                        if (tx_busy) err_set = 1'b1;
                        else begin
                            tx_load = 1'b1;
                            tx_len  = LEN_W'(2);
                            tx_data[MAXB*8-1 -: 16] = {4'b0, pend_left, 6'b0, pass_now, err};
                        end
                    end
                    OP_SETT: begin
                        if (tx_busy) err_set = 1'b1;
                        else begin
                            tx_load = 1'b1;
                            tx_len  = LEN_W'(MAXB);
                            tx_data[MAXB*8-1 -: RUN_W] = run_num;
                        end
                    end
                    default: err_set = 1'b1;
                endcase
            end else begin
                if (cnt == '0) begin
                    nx_st = PS_OPCODE;
                    if (is_thr) begin
                        if (chan_byte < 8'(NCH_USED)) begin
                            ld_dac   = 1'b1;
                            set_bits = agent_bit(AG_DAC);
                        end else begin
                            err_set = 1'b1;
                        end
                    end else begin
                        ld_run = 1'b1;
                    end
                end else begin
                    nx_cnt = cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_OPCODE;
            cnt       <= '0;
            is_thr    <= 1'b0;
            sr        <= '0;
            pend      <= '0;
            err       <= 1'b0;
            last_pass <= 1'b0;
            dac_chan  <= '0;
            dac_word  <= '0;
            run_num   <= '0;
        end else begin
            st     <= nx_st;
            cnt    <= nx_cnt;
            is_thr <= nx_thr;
            pend   <= pend_left | set_bits;
            err    <= err | err_set;
            if (ack_eff[AG_VFY]) last_pass <= vfy_pass;
            if (bv && st == PS_ARGS) sr <= {sr[SR_W-9:0], bdat};
            if (ld_dac) begin
                dac_chan <= chan_byte[CH_W-1:0];
                dac_word <= {sr[DAC_W-9:0], bdat};
            end
            if (ld_run) run_num <= {sr[RUN_W-9:0], bdat};
        end
    end
endmodule

// File: rtl/cmdec_reply_tx.sv
module cmdec_reply_tx #(
    parameter int MAXB  = 4,
    parameter int LEN_W = 3,
    parameter int HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MAXB*8-1:0] data,
    input  logic [LEN_W-1:0]  len,
    output logic [7:0]        dout,
    output logic              stb,
    output logic              busy
);
    localparam int HW = $clog2(HOLD + 1);

    logic [MAXB*8-1:0] shf;
    logic [LEN_W-1:0]  left;
    logic [HW-1:0]     cnt;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shf    <= '0;
            left   <= '0;
            cnt    <= '0;
            active <= 1'b0;
            stb    <= 1'b0;
            dout   <= '0;
        end else if (!active) begin
            if (load) begin
                shf    <= data;
                dout   <= data[MAXB*8-1 -: 8];
                left   <= len;
                cnt    <= '0;
                stb    <= 1'b1;
                active <= 1'b1;
            end
        end else if (cnt == HW'(HOLD - 1)) begin
            cnt <= '0;
            if (stb) begin
                stb <= 1'b0;
            end else if (left > LEN_W'(1)) begin
                left <= left - LEN_W'(1);
                shf  <= shf << 8;
                dout <= shf[MAXB*8-9 -: 8];
                stb  <= 1'b1;
            end else begin
                left   <= '0;
                active <= 1'b0;
            end
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

    assign busy = active;
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import cmdec_pkg::*;
#(
    parameter int RUN_W    = 32,
    parameter int DAC_W    = 16,
    parameter int NCH_USED = 4,
    parameter int SYNC     = 2,
    parameter int HOLD     = 4,
    parameter int CH_W     = $clog2(NCH_USED)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       host_din,
    input  logic             host_stb_in,
    output logic [7:0]       host_dout,
    output logic             host_stb_out,
    output logic             rd_req,
    input  logic             rd_ack,
    output logic             dac_req,
    output logic [CH_W-1:0]  dac_chan,
    output logic [DAC_W-1:0] dac_word,
    input  logic             dac_ack,
    output logic             cfg_req,
    input  logic             cfg_ack,
    output logic             vfy_req,
    input  logic             vfy_ack,
    input  logic             vfy_pass,
    output logic [RUN_W-1:0] run_num
);
    localparam int MAXB  = RUN_W / 8;
    localparam int LEN_W = $clog2(MAXB + 1);

    logic                  bv, tx_load, tx_busy;
    logic [7:0]            bdat;
    logic [NUM_AGENTS-1:0] pend, ackv;
    logic [MAXB*8-1:0]     tx_data;
    logic [LEN_W-1:0]      tx_len;

    assign ackv = {vfy_ack, cfg_ack, dac_ack, rd_ack};

    cmdec_strobe_rx #(.SYNC(SYNC), .BW(8)) u_rx (
        .clk(clk), .rst(rst), .din(host_din), .stb(host_stb_in),
        .byte_valid(bv), .byte_data(bdat)
    );

    cmdec_parser #(
        .RUN_W(RUN_W), .DAC_W(DAC_W), .NCH_USED(NCH_USED),
        .CH_W(CH_W), .MAXB(MAXB), .LEN_W(LEN_W)
    ) u_parse (
        .clk(clk), .rst(rst), .bv(bv), .bdat(bdat), .ack(ackv),
        .vfy_pass(vfy_pass), .tx_busy(tx_busy), .pend(pend),
        .dac_chan(dac_chan), .dac_word(dac_word), .run_num(run_num),
        .tx_load(tx_load), .tx_data(tx_data), .tx_len(tx_len)
    );

    cmdec_reply_tx #(.MAXB(MAXB), .LEN_W(LEN_W), .HOLD(HOLD)) u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .data(tx_data), .len(tx_len),
        .dout(host_dout), .stb(host_stb_out), .busy(tx_busy)
    );

    assign rd_req  = pend[AG_RD];
    assign dac_req = pend[AG_DAC];
    assign cfg_req = pend[AG_CFG];
    assign vfy_req = pend[AG_VFY];
endmodule

// File: rtl/cmdec_checker.sv
module cmdec_checker #(
    parameter int RUN_W = 32,
    parameter int DAC_W = 16,
    parameter int CH_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       host_dout,
    input logic             host_stb_out,
    input logic             rd_req,
    input logic             rd_ack,
    input logic             dac_req,
    input logic [CH_W-1:0]  dac_chan,
    input logic [DAC_W-1:0] dac_word,
    input logic             dac_ack,
    input logic             cfg_req,
    input logic             cfg_ack,
    input logic             vfy_req,
    input logic             vfy_ack,
    input logic [RUN_W-1:0] run_num
);
    logic [3:0] reqv, ackv;
    assign reqv = {vfy_req, cfg_req, dac_req, rd_req};
    assign ackv = {vfy_ack, cfg_ack, dac_ack, rd_ack};

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reqv)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|(reqv & ~ackv)) |=> ((reqv & $past(reqv & ~ackv)) == $past(reqv & ~ackv))); // R3

    AST_DAC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (dac_req && !dac_ack) |=> ($stable(dac_word) && $stable(dac_chan))); // R4

    AST_REPLY_STEADY: assert property (@(posedge clk) disable iff (rst)
        (host_stb_out && $past(host_stb_out)) |-> $stable(host_dout)); // R7

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reqv == 4'b0 && !host_stb_out && run_num == '0)); // R1
endmodule

bind cmd_decoder cmdec_checker #(.RUN_W(RUN_W), .DAC_W(DAC_W), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .host_dout(host_dout), .host_stb_out(host_stb_out),
    .rd_req(rd_req), .rd_ack(rd_ack), .dac_req(dac_req), .dac_chan(dac_chan),
    .dac_word(dac_word), .dac_ack(dac_ack), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
    .vfy_req(vfy_req), .vfy_ack(vfy_ack), .run_num(run_num)
);

// File: tb/tb_cmd_decoder.sv
module tb_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_din = '0;
    logic        host_stb_in = 1'b0;
    logic [7:0]  host_dout;
    logic        host_stb_out;
    logic        rd_req, dac_req, cfg_req, vfy_req;
    logic [1:0]  dac_chan;
    logic [15:0] dac_word;
    logic [31:0] run_num;
    logic [3:0]  ackv = '0;
    logic        vfy_pass = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] rx [8];
    int rx_n = 0;

    always #5 clk = ~clk;

    cmd_decoder dut (
        .clk(clk), .rst(rst), .host_din(host_din), .host_stb_in(host_stb_in),
        .host_dout(host_dout), .host_stb_out(host_stb_out),
        .rd_req(rd_req), .rd_ack(ackv[0]), .dac_req(dac_req), .dac_chan(dac_chan),
        .dac_word(dac_word), .dac_ack(ackv[1]), .cfg_req(cfg_req), .cfg_ack(ackv[2]),
        .vfy_req(vfy_req), .vfy_ack(ackv[3]), .vfy_pass(vfy_pass), .run_num(run_num)
    );

    wire [3:0] reqv = {vfy_req, cfg_req, dac_req, rd_req};

    always @(posedge host_stb_out) begin
        #1;
        if (rx_n < 8) rx[rx_n] = host_dout;
        rx_n++;
    end

    typedef struct packed {
        logic [2:0]  nb;
        logic [31:0] bytes;
        logic [3:0]  exp_req;
        logic [1:0]  ch;
        logic [15:0] word;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{3'd1, 32'h01000000, 4'b0001, 2'd0, 16'h0000},
        '{3'd1, 32'h03000000, 4'b0100, 2'd0, 16'h0000},
        '{3'd1, 32'h04000000, 4'b1000, 2'd0, 16'h0000},
        '{3'd4, 32'h0201ABCD, 4'b0010, 2'd1, 16'hABCD},
        '{3'd4, 32'h020300FF, 4'b0010, 2'd3, 16'h00FF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int hold_hi = 6);
        @(negedge clk);
        host_din = b;
        host_stb_in = 1'b1;
        repeat (hold_hi) @(negedge clk);
        host_stb_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // ack asserted in exactly the cycle the byte is decoded
    task automatic send_byte_ack(input logic [7:0] b, input logic [3:0] m);
        @(negedge clk);
        host_din = b;
        host_stb_in = 1'b1;
        repeat (2) @(negedge clk);
        ackv = m;
        @(negedge clk);
        ackv = '0;
        repeat (3) @(negedge clk);
        host_stb_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic [3:0] m, input logic pass = 1'b0);
        @(negedge clk);
        ackv = m;
        vfy_pass = pass;
        @(negedge clk);
        ackv = '0;
        vfy_pass = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
        rx_n = 0;
        send_byte(8'h05);
        repeat (25) @(negedge clk);
        check("R8 status length", 32'(rx_n), 32'd2);
        s0 = rx[0];
        s1 = rx[1];
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        ackv = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s0, s1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 requests idle", 32'(reqv), 32'd0);
        check("R1 strobe out low", 32'(host_stb_out), 32'd0);
        check("R1 run number zero", run_num, 32'd0);
        read_status(s0, s1);
        check("R1 status byte0", 32'(s0), 32'h00);
        check("R1 status byte1", 32'(s1), 32'h00);

        // R3 / R4: table of dispatch commands
        for (int i = 0; i < 5; i++) begin
            for (int k = 0; k < int'(VECS[i].nb); k++)
                send_byte(VECS[i].bytes[31 - 8*k -: 8]);
            check("R3 R4 request raised", 32'(reqv), 32'(VECS[i].exp_req));
            if (VECS[i].exp_req[1]) begin
                check("R4 dac channel", 32'(dac_chan), 32'(VECS[i].ch));
                check("R4 dac word", 32'(dac_word), 32'(VECS[i].word));
            end
            repeat (5) @(negedge clk);
            check("R3 request held until ack", 32'(reqv), 32'(VECS[i].exp_req));
            pulse_ack(VECS[i].exp_req);
            check("R3 request cleared by ack", 32'(reqv), 32'd0);
        end

        // R2: long strobe delivers one byte only
        send_byte(8'h03, 30);
        check("R2 configure raised once", 32'(reqv), 32'b0100);
        pulse_ack(4'b0100);
        read_status(s0, s1);
        check("R2 no second byte seen", 32'(s1), 32'h00);

        // R12: verify pass captured
        send_byte(8'h04);
        pulse_ack(4'b1000, 1'b1);
        read_status(s0, s1);
        check("R12 verify pass recorded", 32'(s1), 32'h02);

        // R6 / R7: run number write and readback
        send_byte(8'h06); send_byte(8'hDE); send_byte(8'hAD);
        send_byte(8'hBE); send_byte(8'hEF);
        check("R6 run number loaded", run_num, 32'hDEADBEEF);
        rx_n = 0;
        send_byte(8'h07);
        repeat (40) @(negedge clk);
        check("R7 settings length", 32'(rx_n), 32'd4);
        check("R7 settings bytes", {rx[0], rx[1], rx[2], rx[3]}, 32'hDEADBEEF);

        // R10: commands dropped while busy, status still answered
        send_byte(8'h01);
        send_byte(8'h03);
        check("R10 second dispatch dropped", 32'(reqv), 32'b0001);
        read_status(s0, s1);
        check("R10 busy shown in status", 32'(s0), 32'h01);
        check("R10 error and pass in status", 32'(s1), 32'h03);
        pulse_ack(4'b0001);
        send_byte(8'h06); send_byte(8'h11); send_byte(8'h22);
        send_byte(8'h33); send_byte(8'h44);
        check("R10 run write accepted when idle", run_num, 32'h11223344);

        // R9: unknown opcode
        apply_reset();
        send_byte(8'h5A);
        check("R9 no request on unknown", 32'(reqv), 32'd0);
        read_status(s0, s1);
        check("R9 error set", 32'(s1), 32'h01);
        send_byte(8'h01);
        pulse_ack(4'b0001);
        read_status(s0, s1);
        check("R9 error sticky", 32'(s1), 32'h01);

        // R5: channel out of range
        apply_reset();
        send_byte(8'h02); send_byte(8'h04); send_byte(8'h11); send_byte(8'h22);
        check("R5 no threshold request", 32'(reqv), 32'd0);
        check("R5 dac word untouched", 32'(dac_word), 32'h0000);
        read_status(s0, s1);
        check("R5 error set", 32'(s1), 32'h01);

        // R11: ack in the same cycle as the decoded opcode
        apply_reset();
        send_byte(8'h03);
        rx_n = 0;
        send_byte_ack(8'h05, 4'b0100);
        repeat (25) @(negedge clk);
        check("R11 status sees agent idle", 32'(rx[0]), 32'h00);
        check("R11 configure cleared", 32'(reqv), 32'd0);
        send_byte(8'h03);
        send_byte_ack(8'h01, 4'b0100);
        check("R11 data request accepted", 32'(reqv), 32'b0001);
        pulse_ack(4'b0001);
        read_status(s0, s1);
        check("R11 no error flagged", 32'(s1), 32'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule